// File: doc/BRIEF.md
# Polled Entropy Seed Source

The block sits between a raw noise bit stream and a processor read port. Every valid raw sample is checked by two continuous health tests. After a startup self-test window, samples are folded into conditioned bits, and the conditioned bits are gathered into 16-bit seed words. A poll strobe returns one 32-bit word. That word holds either a fresh seed or a status, and the block changes state in the same cycle, so a seed is handed out at most once. A separate raw read path exposes the most recent raw samples for test. While that path is enabled, no seed can leave the block.

The control is a five-state machine:

- `ST_BIST` is the startup self-test.
- `ST_WAIT` is accumulating.
- `ST_READY` means a seed is held.
- `ST_TEST` is raw test mode.
- `ST_DEAD` is health failure.

Its transitions are:

- **startup-pass**: `ST_BIST` goes to `ST_WAIT`, or to `ST_TEST` if test mode is on, when the startup window ends with no health failure.
- **seed-full**: `ST_WAIT` goes to `ST_READY` when 16 conditioned bits are held.
- **consume**: `ST_READY` goes to `ST_WAIT` on a poll.
- **enter-test**: `ST_WAIT` or `ST_READY` goes to `ST_TEST` when `test_en` rises. Any pending seed is dropped.
- **leave-test**: `ST_TEST` goes to `ST_WAIT` when `test_en` falls. The accumulator is emptied.
- **health-fail**: any state goes to `ST_DEAD` on a health failure.

`ST_DEAD` has no exit except reset.

Top module: `es_poll_unit`

## Requirements
- R1: After reset `poll_word` and `raw_word` are zero. Polls return the self-test code until 1024 valid raw samples have been taken with no health failure. The poll after the 1024th such sample returns the wait code.
- R2: A poll updates `poll_word` on the clock edge that samples `poll_req`. The word is laid out as follows:
  - Bits 31:30 carry the status: 00 self-test, 01 wait, 10 seed valid, 11 dead.
  - Bits 15:0 carry the seed when the status is 10, and are zero otherwise.
  - Bits 29:16 are zero.
- R3: After startup, each conditioned bit is the XOR of 4 consecutive valid raw samples. Conditioned bits shift into the seed from bit 0 upward, so the first one ends in bit 15. Polls return wait until all 16 conditioned bits are held.
- R4: A seed returned by a poll is consumed. The next poll returns wait, and the next seed is built only from samples taken after the consuming poll.
- R5: 32 identical consecutive valid samples cause the dead state. A run of 31 does not.
- R6: Samples are grouped into back-to-back windows of 1024 starting at reset. More than 800 occurrences of one value within a window cause the dead state. Exactly 800 do not.
- R7: The dead state persists until reset whatever the inputs do, and polls report code 11.
- R8: While `test_en` is high:
  - Polls return the wait code, and a pending seed is discarded.
  - `raw_rd` loads `raw_word` with the 16 most recent valid raw samples, the newest in bit 0.
  - After `test_en` falls, seed accumulation restarts from empty.
- R9: `raw_rd` with `test_en` low loads zero into `raw_word`.
- R10: Cycles with `noise_vld` low are not samples. `noise_bit` is ignored in those cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| noise_bit | input | 1 | Raw noise sample |
| noise_vld | input | 1 | Qualifies `noise_bit` for this cycle |
| poll_req | input | 1 | One-cycle poll strobe |
| test_en | input | 1 | Raw test mode enable |
| raw_rd | input | 1 | One-cycle raw read strobe |
| poll_word | output | 32 | Status code and seed from the last poll |
| raw_word | output | 16 | Raw samples from the last raw read |

## Verification
The bench probes each threshold on both sides:

- **Startup count**: it polls after the 1023rd startup sample and again after the 1024th. An off-by-one counter would report wait one sample early, or stay in self-test.
- **Repetition test**: it sends a run of 31 equal bits and then one of 32. A wrong run limit would kill a healthy source or miss the stuck one.
- **Proportion test**: it sends a window holding exactly 800 ones, then a pattern whose 801st one lands on a known sample. A comparison off by one would flag the first or miss the second.
- **Seed handling**: it checks that a partly filled seed is never reported, that a second poll never sees the same seed, that raising test mode drops a ready seed, and that leaving test mode starts the fold from empty. Idle cycles with a toggling `noise_bit` are inserted between groups, so a design that sampled without `noise_vld` would produce wrong seeds.

// File: rtl/es_poll_pkg.sv
package es_poll_pkg;

    typedef enum logic [2:0] {
        ST_BIST,
        ST_WAIT,
        ST_READY,
        ST_TEST,
        ST_DEAD
    } es_state_e;

    typedef enum logic [1:0] {
        CODE_BIST = 2'b00,
        CODE_WAIT = 2'b01,
        CODE_SEED = 2'b10,
        CODE_DEAD = 2'b11
    } es_code_e;

endpackage

// File: rtl/es_health.sv
module es_health #(
    parameter int REP_LIMIT  = 32,
    parameter int APT_WIN    = 1024,
    parameter int APT_CUTOFF = 800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_bit,
    input  logic smp_vld,
    output logic fail
);
    localparam int RW = $clog2(REP_LIMIT + 1);
    localparam int WW = $clog2(APT_WIN);
    localparam int CW = $clog2(APT_WIN + 1);

    logic          last_q;
    logic [RW-1:0] run_q;
    logic [WW-1:0] win_q;
    logic [CW-1:0] ones_q;
    logic [CW-1:0] zeros_q;

    logic same, rep_hit, apt_hit, win_end;

    always_comb begin
        same    = (run_q != '0) && (smp_bit == last_q);
        rep_hit = same && (run_q == RW'(REP_LIMIT - 1));
        apt_hit = smp_bit ? (ones_q == CW'(APT_CUTOFF)) : (zeros_q == CW'(APT_CUTOFF));
        win_end = (win_q == WW'(APT_WIN - 1));
        fail    = smp_vld && (rep_hit || apt_hit);
    end

    // repetition run tracker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
            run_q  <= '0;
        end else if (smp_vld) begin
            last_q <= smp_bit;
            if (!same)
                run_q <= RW'(1);
            else if (!rep_hit)
                run_q <= run_q + RW'(1);
        end
    end

    // proportion window counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q   <= '0;
            ones_q  <= '0;
            zeros_q <= '0;
        end else if (smp_vld) begin
            if (win_end) begin
                win_q   <= '0;
                ones_q  <= '0;
                zeros_q <= '0;
            end else begin
                win_q <= win_q + WW'(1);
                if (smp_bit)
                    ones_q <= ones_q + CW'(1);
                else
                    zeros_q <= zeros_q + CW'(1);
            end
        end
    end

    // R5
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RW'(REP_LIMIT));

    // R6
    apt_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (CW'(ones_q) + CW'(zeros_q)) == CW'(win_q));

endmodule

// File: rtl/es_cond.sv
module es_cond #(
    parameter int SEED_W = 16,
    parameter int FOLD   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic              smp_bit,
    input  logic              smp_vld,
    output logic              full,
    output logic [SEED_W-1:0] seed
);
    localparam int FW = (FOLD > 1) ? $clog2(FOLD) : 1;
    localparam int SW = $clog2(SEED_W + 1);

    logic          fold_q;
    logic [FW-1:0] phase_q;
    logic [SW-1:0] nbits_q;
    logic [SEED_W-1:0] seed_q;
    logic take, fbit, group_end;

    always_comb begin
        full      = (nbits_q == SW'(SEED_W));
        take      = en && smp_vld && !full;
        fbit      = fold_q ^ smp_bit;
        group_end = (phase_q == FW'(FOLD - 1));
        seed      = seed_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            fold_q  <= 1'b0;
            phase_q <= '0;
            nbits_q <= '0;
            seed_q  <= '0;
        end else if (take) begin
            if (group_end) begin
                fold_q  <= 1'b0;
                phase_q <= '0;
                nbits_q <= nbits_q + SW'(1);
                seed_q  <= {seed_q[SEED_W-2:0], fbit};
            end else begin
                fold_q  <= fbit;
                phase_q <= phase_q + FW'(1);
            end
        end
    end

    // R3
    seed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !clr) |=> (full && $stable(seed_q)));

endmodule

// File: rtl/es_poll_unit.sv
module es_poll_unit
    import es_poll_pkg::*;
#(
    parameter int SEED_W     = 16,
    parameter int FOLD       = 4,
    parameter int REP_LIMIT  = 32,
    parameter int APT_WIN    = 1024,
    parameter int APT_CUTOFF = 800,
    parameter int STARTUP    = 1024,
    parameter int RAW_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             noise_bit,
    input  logic             noise_vld,
    input  logic             poll_req,
    input  logic             test_en,
    input  logic             raw_rd,
    output logic [31:0]      poll_word,
    output logic [RAW_W-1:0] raw_word
);
    localparam int STW   = $clog2(STARTUP);
    localparam int PAD_W = 30 - SEED_W;

    es_state_e         state_q, state_d;
    logic [STW-1:0]    st_cnt_q;
    logic              hfail;
    logic              cond_full, cond_clr, cond_en;
    logic [SEED_W-1:0] cond_seed;
    logic [RAW_W-1:0]  raw_sr_q;
    es_code_e          code;
    logic              st_last;

    es_health #(
        .REP_LIMIT (REP_LIMIT),
        .APT_WIN   (APT_WIN),
        .APT_CUTOFF(APT_CUTOFF)
    ) health_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp_bit(noise_bit),
        .smp_vld(noise_vld),
        .fail   (hfail)
    );

    es_cond #(
        .SEED_W(SEED_W),
        .FOLD  (FOLD)
    ) cond_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cond_clr),
        .en     (cond_en),
        .smp_bit(noise_bit),
        .smp_vld(noise_vld),
        .full   (cond_full),
        .seed   (cond_seed)
    );

    always_comb begin
        cond_en  = (state_q == ST_WAIT);
        cond_clr = !((state_q == ST_WAIT) || (state_q == ST_READY))
                   || ((state_q == ST_READY) && poll_req);
        st_last  = noise_vld && (st_cnt_q == STW'(STARTUP - 1));
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BIST: begin
                if (hfail)        state_d = ST_DEAD;
                else if (st_last) state_d = test_en ? ST_TEST : ST_WAIT;
            end
            ST_WAIT: begin
                if (hfail)          state_d = ST_DEAD;
                else if (test_en)   state_d = ST_TEST;
                else if (cond_full) state_d = ST_READY;
            end
            ST_READY: begin
                if (hfail)         state_d = ST_DEAD;
                else if (test_en)  state_d = ST_TEST;
                else if (poll_req) state_d = ST_WAIT;
            end
            ST_TEST: begin
                if (hfail)         state_d = ST_DEAD;
                else if (!test_en) state_d = ST_WAIT;
            end
            ST_DEAD: state_d = ST_DEAD;
            default: state_d = ST_DEAD;
        endcase
    end

    // state register and startup counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_BIST;
            st_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_BIST && noise_vld)
                st_cnt_q <= st_cnt_q + STW'(1);
        end
    end

    always_comb begin
        if (state_q == ST_DEAD)       code = CODE_DEAD;
        else if (test_en)             code = CODE_WAIT;
        else if (state_q == ST_BIST)  code = CODE_BIST;
        else if (state_q == ST_READY) code = CODE_SEED;
        else                          code = CODE_WAIT;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            poll_word <= '0;
            raw_word  <= '0;
            raw_sr_q  <= '0;
        end else begin
            if (noise_vld)
                raw_sr_q <= {raw_sr_q[RAW_W-2:0], noise_bit};
            if (poll_req)
                poll_word <= {code, {PAD_W{1'b0}},
                              (code == CODE_SEED) ? cond_seed : {SEED_W{1'b0}}};
            if (raw_rd)
                raw_word <= test_en ? raw_sr_q : '0;
        end
    end

    // R1
    bist_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BIST && poll_req && !test_en) |=> (poll_word == 32'h0));

    // R4
    seed_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY && poll_req) |=> (state_q != ST_READY));

    // R5
    fail_to_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hfail |=> (state_q == ST_DEAD));

    // R7
    dead_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEAD) |=> (state_q == ST_DEAD));

    // R8
    test_no_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && poll_req) |=> (poll_word[31:30] != CODE_SEED));

endmodule

// File: tb/es_poll_unit_tb.sv
module es_poll_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        noise_bit = 1'b0;
    logic        noise_vld = 1'b0;
    logic        poll_req = 1'b0;
    logic        test_en = 1'b0;
    logic        raw_rd = 1'b0;
    logic [31:0] poll_word;
    logic [15:0] raw_word;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [15:0] hist = 16'h0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    es_poll_unit dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .noise_bit(noise_bit),
        .noise_vld(noise_vld),
        .poll_req (poll_req),
        .test_en  (test_en),
        .raw_rd   (raw_rd),
        .poll_word(poll_word),
        .raw_word (raw_word)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send(input logic b);
        noise_bit = b;
        noise_vld = 1'b1;
        @(negedge clk);
        noise_vld = 1'b0;
        hist = {hist[14:0], b};
    endtask

    task automatic send_lfsr(output logic b);
        b = lfsr[0];
        lfsr = {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
        send(b);
    endtask

    task automatic send_rand(input int n);
        for (int i = 0; i < n; i++) begin
            logic b;
            send_lfsr(b);
        end
    endtask

    // R3, R10: each group of 4 samples folds to one bit; a gap cycle with a
    // toggled noise_bit and noise_vld low follows each group
    task automatic feed(input int ng, inout logic [15:0] s);
        for (int g = 0; g < ng; g++) begin
            logic f;
            f = 1'b0;
            for (int k = 0; k < 4; k++) begin
                logic b;
                send_lfsr(b);
                f = f ^ b;
            end
            s = {s[14:0], f};
            noise_bit = ~noise_bit;
            @(negedge clk);
        end
    endtask

    task automatic do_poll(output logic [31:0] w);
        poll_req = 1'b1;
        @(negedge clk);
        poll_req = 1'b0;
        w = poll_word;
    endtask

    task automatic do_raw(output logic [15:0] w);
        raw_rd = 1'b1;
        @(negedge clk);
        raw_rd = 1'b0;
        w = raw_word;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        hist = 16'h0;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        logic [15:0] r;
        logic [15:0] s;

        @(negedge clk);
        do_reset();
        chk("R1 reset poll_word", poll_word, 32'h0);
        chk("R1 reset raw_word", {16'h0, raw_word}, 32'h0);

        send_rand(500);
        do_poll(w);
        chk("R1 mid-startup", w, 32'h0000_0000);
        send_rand(523);
        do_poll(w);
        chk("R1 after 1023 samples", w, 32'h0000_0000);
        send_rand(1);
        do_poll(w);
        chk("R1 R2 after 1024 samples wait", w, 32'h4000_0000);

        do_raw(r);
        chk("R9 raw read outside test", {16'h0, r}, 32'h0);

        s = 16'h0;
        feed(15, s);
        idle(1);
        do_poll(w);
        chk("R3 15 conditioned bits still wait", w, 32'h4000_0000);
        feed(1, s);
        idle(1);
        do_poll(w);
        chk("R2 R3 R10 first seed", w, {16'h8000, s});
        do_poll(w);
        chk("R4 consumed seed", w, 32'h4000_0000);

        for (int n = 0; n < 3; n++) begin
            s = 16'h0;
            feed(16, s);
            idle(1);
            do_poll(w);
            chk("R2 R3 seed sweep", w, {16'h8000, s});
            do_poll(w);
            chk("R4 seed sweep consumed", w, 32'h4000_0000);
        end

        s = 16'h0;
        feed(16, s);
        idle(1);
        test_en = 1'b1;
        @(negedge clk);
        do_poll(w);
        chk("R8 test mode hides seed", w, 32'h4000_0000);
        send_rand(20);
        do_raw(r);
        chk("R8 raw read latest bits", {16'h0, r}, {16'h0, hist});
        send_rand(5);
        do_raw(r);
        chk("R8 raw read after more bits", {16'h0, r}, {16'h0, hist});
        do_poll(w);
        chk("R8 test mode poll wait", w, 32'h4000_0000);
        test_en = 1'b0;
        @(negedge clk);
        do_raw(r);
        chk("R9 raw read after test", {16'h0, r}, 32'h0);
        s = 16'h0;
        feed(16, s);
        idle(1);
        do_poll(w);
        chk("R8 restart from empty", w, {16'h8000, s});

        send(1'b0);
        for (int i = 0; i < 31; i++) send(1'b1);
        do_poll(w);
        chk("R5 run of 31 tolerated", w, 32'h4000_0000);
        send(1'b0);
        for (int i = 0; i < 32; i++) send(1'b1);
        do_poll(w);
        chk("R5 run of 32 dead", w, 32'hC000_0000);

        send_rand(200);
        test_en = 1'b1;
        send_rand(10);
        test_en = 1'b0;
        idle(2);
        do_poll(w);
        chk("R7 dead persists", w, 32'hC000_0000);
        do_poll(w);
        chk("R7 dead on repeated poll", w, 32'hC000_0000);

        do_reset();
        for (int i = 0; i < 1024; i++) send((i % 32) >= 7);
        do_poll(w);
        chk("R6 exactly 800 ones passes", w, 32'h4000_0000);
        test_en = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 854; i++) send((i % 16) != 0);
        do_poll(w);
        chk("R6 800 ones in window alive", w, 32'h4000_0000);
        send(1'b1);
        do_poll(w);
        chk("R6 801st one dead", w, 32'hC000_0000);
        test_en = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule